// File: doc/BRIEF.md
# Oscillator Startup Delay Timer

This block decides when a freshly enabled oscillator may be treated as running. Software writes a control word that holds an enable bit and an 8-bit startup count. The block loads the count and restarts a divide-by-eight prescaler on the slow reference clock. It then lowers the count by one on every prescaler tick. When a tick finds the count already at zero, the block raises a stable flag. Clearing the enable bit drops the flag in the same write. Writing a new enabling control word also drops the flag and starts the countdown again.

An interrupt mask register gates the stable flag onto a level-sensitive interrupt line. A bypass bit marks that an external clock drives the oscillator input. While the bypass bit is set, the oscillator drive output stays off. The whole block, including its register port, runs in the slow-clock domain. The oscillator itself lies outside the block; the block controls it only through its drive output.

Top module: `osc_startup_timer`

## Requirements
- R1: A write to address 0 with bit 0 clear drops the stable flag and halts any countdown at that clock edge. The flag then stays low until a later enabling write completes its countdown.
- R2: A write to address 0 with bit 0 set clears the stable flag. It loads the remaining count from bits 15:8 of the written word, restarts the prescaler and starts counting. Status then reads 2, which means counting and not stable.
- R3: While counting, the remaining count (read at address 3, bits 7:0) falls by one at each prescaler tick. The ticks come every 8 clock cycles, counted from the enabling write.
- R4: A tick that finds the remaining count at zero sets the stable flag. The flag is therefore first seen high exactly 8*(N+1) clock edges after the enabling write with count N. A count of 0 takes 8 edges and a count of 255 takes 2048.
- R5: An enabling write made during a countdown restarts it from the new count. All earlier progress is discarded.
- R6: irq_o is high exactly when the stable flag is high and bit 0 of the mask register (address 1) is set.
- R7: osc_en_o equals control bit 0 AND NOT control bit 1 (bypass), and bypass_o equals control bit 1.
- R8: After reset, all outputs are low and all four readable addresses return 0.
- R9: Once set, the stable flag holds until the next write to address 0. Writes to the mask register do not change it.
- R10: Readback gives the last control word at address 0 (bit 0 enable, bit 1 bypass, bits 15:8 count). It gives the mask at address 1, bit 0. Address 2 returns status with bit 0 stable and bit 1 counting. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Combinational read data |
| osc_en_o | output | 1 | Oscillator drive enable |
| bypass_o | output | 1 | External clock bypass select |
| stable_o | output | 1 | Oscillator stable flag |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the register strobe carries a defined address and data on every cycle where it is high. They also assume that an enabling write may arrive at any phase of the prescaler. The tick-spacing and decrement properties measure intervals from the last enabling write, so they hold only if nothing other than a control write restarts the timer. The stimulus drives writes only on falling clock edges, one control or mask word at a time. It draws random counts and mask settings from a fixed seed, and adds directed cases for count zero, the full count of 255, disabling in the middle of a countdown, restarting, and bypass.

// File: rtl/ost_pkg.sv
package ost_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MASK = 2'd1,
    SEL_STAT = 2'd2,
    SEL_LEFT = 2'd3
  } ost_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_BYP_BIT = 1;
  localparam int CTRL_CNT_LSB = 8;
  localparam int STAT_OK_BIT  = 0;
  localparam int STAT_RUN_BIT = 1;
endpackage

// File: rtl/ost_prescaler.sv
module ost_prescaler #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam logic [DIV_LOG2-1:0] LAST = {DIV_LOG2{1'b1}};

  logic [DIV_LOG2-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase_q <= '0;
    else if (restart || !run)  phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end

  assign tick = run && !restart && (phase_q == LAST);
endmodule

// File: rtl/ost_countdown.sv
module ost_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             halt,
  input  logic             tick,
  output logic [CNT_W-1:0] remaining,
  output logic             counting,
  output logic             stable,
  output logic             expire
);
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [CNT_W-1:0] rem_q;
  logic             run_q, ok_q;

  assign expire = tick && run_q && (rem_q == '0) && !load && !halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      run_q <= 1'b0;
      ok_q  <= 1'b0;
    end else if (load) begin
      rem_q <= load_val;
      run_q <= 1'b1;
      ok_q  <= 1'b0;
    end else if (halt) begin
      rem_q <= '0;
      run_q <= 1'b0;
      ok_q  <= 1'b0;
    end else if (expire) begin
      run_q <= 1'b0;
      ok_q  <= 1'b1;
    end else if (tick && run_q) begin
      rem_q <= step_down(rem_q);
    end
  end

  assign remaining = rem_q;
  assign counting  = run_q;
  assign stable    = ok_q;
endmodule

// File: rtl/ost_regs.sv
module ost_regs
  import ost_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stable,
  input  logic              counting,
  input  logic [CNT_W-1:0]  remaining,
  output logic              en_q,
  output logic              byp_q,
  output logic              mask_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              load,
  output logic              halt
);
  logic wr_ctrl, wr_mask;

  assign wr_ctrl = wr_en && (ost_sel_e'(wr_addr) == SEL_CTRL);
  assign wr_mask = wr_en && (ost_sel_e'(wr_addr) == SEL_MASK);
  assign load    = wr_ctrl &&  wr_data[CTRL_EN_BIT];
  assign halt    = wr_ctrl && !wr_data[CTRL_EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      byp_q  <= 1'b0;
      cnt_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wr_data[CTRL_EN_BIT];
        byp_q <= wr_data[CTRL_BYP_BIT];
        cnt_q <= wr_data[CTRL_CNT_LSB +: CNT_W];
      end
      if (wr_mask) mask_q <= wr_data[0];
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (ost_sel_e'(rd_addr))
      SEL_CTRL: begin
        rd_data[CTRL_EN_BIT]             = en_q;
        rd_data[CTRL_BYP_BIT]            = byp_q;
        rd_data[CTRL_CNT_LSB +: CNT_W]   = cnt_q;
      end
      SEL_MASK: rd_data[0] = mask_q;
      SEL_STAT: begin
        rd_data[STAT_OK_BIT]  = stable;
        rd_data[STAT_RUN_BIT] = counting;
      end
      SEL_LEFT: rd_data[CNT_W-1:0] = remaining;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/osc_startup_timer.sv
module osc_startup_timer #(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 8,
  parameter int DIV_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              osc_en_o,
  output logic              bypass_o,
  output logic              stable_o,
  output logic              irq_o
);
  logic             tick_w, load_w, halt_w, expire_w;
  logic             counting_w, stable_w;
  logic             en_w, byp_w, mask_w;
  logic [CNT_W-1:0] remaining_w, cnt_w;

  ost_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .stable(stable_w), .counting(counting_w), .remaining(remaining_w),
    .en_q(en_w), .byp_q(byp_w), .mask_q(mask_w), .cnt_q(cnt_w),
    .load(load_w), .halt(halt_w)
  );

  ost_prescaler #(.DIV_LOG2(DIV_LOG2)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(load_w), .run(counting_w),
    .tick(tick_w)
  );

  ost_countdown #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(load_w),
    .load_val(wr_data[ost_pkg::CTRL_CNT_LSB +: CNT_W]), .halt(halt_w),
    .tick(tick_w), .remaining(remaining_w), .counting(counting_w),
    .stable(stable_w), .expire(expire_w)
  );

  assign osc_en_o = en_w && !byp_w;
  assign bypass_o = byp_w;
  assign stable_o = stable_w;
  assign irq_o    = stable_w && mask_w;
endmodule

// File: rtl/ost_checker.sv
module ost_checker #(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 8,
  parameter int DIV_LOG2 = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              tick,
  input logic [CNT_W-1:0]  remaining,
  input logic              counting,
  input logic              stable,
  input logic              mask,
  input logic              irq,
  input logic              osc_en,
  input logic              bypass
);
  localparam int GAP_W = DIV_LOG2 + 1;
  localparam logic [GAP_W-1:0] GAP_TICK = GAP_W'((1 << DIV_LOG2) - 1);

  logic wr_ctrl;
  logic [GAP_W-1:0] gap_q;

  assign wr_ctrl = wr_en && (wr_addr == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          gap_q <= '0;
    else if ((wr_ctrl && wr_data[0]) || tick) gap_q <= '0;
    else if (gap_q != {GAP_W{1'b1}})     gap_q <= gap_q + 1'b1;
  end

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && !wr_data[0] |=> !stable && !counting); // R1
  AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && wr_data[0] |=> !stable && counting &&
      remaining == $past(wr_data[8 +: CNT_W])); // R2
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> gap_q == GAP_TICK); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    tick && counting && remaining != '0 && !wr_ctrl |=>
      remaining == CNT_W'($past(remaining) - 1'b1)); // R3
  AST_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable) |-> $past(tick) && $past(remaining) == '0); // R4
  AST_STABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stable && !wr_ctrl |=> stable); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !mask |-> !irq); // R6
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stable); // R6
  AST_OSC_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> !osc_en); // R7
endmodule

bind osc_startup_timer ost_checker #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2)
) u_ost_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .tick(tick_w), .remaining(remaining_w),
  .counting(counting_w), .stable(stable_w), .mask(mask_w),
  .irq(irq_o), .osc_en(osc_en_o), .bypass(bypass_o)
);

// File: tb/osc_startup_timer_test.sv
`timescale 1ns/1ps
module osc_startup_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  wire  [15:0] rd_data;
  wire         osc_en_o, bypass_o, stable_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;

  osc_startup_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .osc_en_o(osc_en_o), .bypass_o(bypass_o), .stable_o(stable_o),
    .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  function automatic logic [15:0] ctrl_word(bit en, bit byp, int n);
    return {n[7:0], 6'd0, byp, en};
  endfunction

  function automatic int settle_edges(int n);
    return 8 * (n + 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output int v);
    rd_addr = a; #0.2;
    v = int'(rd_data);
  endtask

  task automatic step(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic run_delay(int n, bit m);
    int v;
    int done;
    done = 0;
    wr(2'd0, ctrl_word(1'b1, 1'b0, n));
    peek(2'd2, v);  chk("R2 status after enable", v, 2);
    peek(2'd3, v);  chk("R2 loaded count", v, n);
    chk("R7 osc drive on", int'(osc_en_o), 1);
    if (n > 0) begin
      step(8); done = 8;
      peek(2'd3, v); chk("R3 count after one tick", v, n - 1);
    end
    step(settle_edges(n) - 1 - done);
    chk("R4 not yet stable", int'(stable_o), 0);
    step(1);
    chk("R4 stable on time", int'(stable_o), 1);
    chk("R6 irq level", int'(irq_o), int'(m));
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'h5eed_0c11));
    step(3);
    chk("R8 reset stable", int'(stable_o), 0);
    chk("R8 reset irq", int'(irq_o), 0);
    chk("R8 reset osc", int'(osc_en_o), 0);
    chk("R8 reset bypass", int'(bypass_o), 0);
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v); chk("R8 reset readback", v, 0);
    end
    @(negedge clk); rst_n = 1'b1;

    // count zero, mask off
    run_delay(0, 1'b0);

    // mask on/off does not disturb stable
    wr(2'd1, 16'd1);
    chk("R6 irq after unmask", int'(irq_o), 1);
    chk("R9 stable kept by mask write", int'(stable_o), 1);
    peek(2'd1, v); chk("R10 mask readback", v, 1);
    wr(2'd1, 16'd0);
    chk("R6 irq masked", int'(irq_o), 0);
    step(50);
    chk("R9 stable holds", int'(stable_o), 1);

    // disable clears
    wr(2'd0, ctrl_word(1'b0, 1'b0, 9));
    chk("R1 disable clears stable", int'(stable_o), 0);
    peek(2'd2, v); chk("R1 status idle", v, 0);
    chk("R7 osc off", int'(osc_en_o), 0);

    // disable during countdown
    wr(2'd0, ctrl_word(1'b1, 1'b0, 4));
    step(10);
    wr(2'd0, ctrl_word(1'b0, 1'b0, 4));
    step(60);
    chk("R1 aborted countdown stays unstable", int'(stable_o), 0);

    // multi-tick with mask
    wr(2'd1, 16'd1);
    run_delay(3, 1'b1);

    // restart mid-countdown
    wr(2'd0, ctrl_word(1'b1, 1'b0, 6));
    step(20);
    wr(2'd0, ctrl_word(1'b1, 1'b0, 2));
    peek(2'd3, v); chk("R5 reloaded count", v, 2);
    step(settle_edges(2) - 1);
    chk("R5 not early after restart", int'(stable_o), 0);
    step(1);
    chk("R5 stable after restart", int'(stable_o), 1);

    // bypass
    wr(2'd0, ctrl_word(1'b0, 1'b1, 0));
    chk("R7 bypass out", int'(bypass_o), 1);
    chk("R7 osc off in bypass", int'(osc_en_o), 0);
    wr(2'd0, ctrl_word(1'b1, 1'b1, 0));
    chk("R7 osc off bypass+en", int'(osc_en_o), 0);
    peek(2'd0, v); chk("R10 ctrl readback", v, int'(ctrl_word(1'b1, 1'b1, 0)));
    wr(2'd0, ctrl_word(1'b1, 1'b0, 77));
    chk("R7 bypass cleared", int'(bypass_o), 0);
    peek(2'd0, v); chk("R10 ctrl readback count", v, int'(ctrl_word(1'b1, 1'b0, 77)));

    // full count
    run_delay(255, 1'b1);

    // random
    for (int i = 0; i < 16; i++) begin
      int n;
      bit m;
      n = int'($urandom_range(0, 30));
      m = 1'($urandom_range(0, 1));
      wr(2'd1, {15'd0, m});
      run_delay(n, m);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule